// File: doc/BRIEF.md
# Multicycle Shared-Memory Processor Datapath

This block is the datapath of a 32-bit load/store processor that spends several clock cycles on each instruction. One memory port carries both instruction fetches and data accesses, and one ALU does every arithmetic job: the PC increment, the branch target, the effective address and the equality compare for branches. The block holds the program counter, the instruction register, the memory data register, the two operand latches, the ALU result register, a 32-entry register file and all the selection muxes.

Every control signal comes in from outside. A separate sequencer reads the opcode and function fields the block drives out and steps it through fetch, decode and the instruction-specific cycles. The shared memory sits outside the block. The block drives the address, the write data and the write strobe, and takes back the read data combinationally within the same cycle. Only the PC and the instruction register have load enables. The operand latches, the ALU result register and the memory data register reload on every clock edge, which lets one ALU be reused from cycle to cycle.

Top module: `mc_datapath`

## Requirements
- R1: Reset is synchronous and active low. A clock edge with `rst_n` low clears the PC and the instruction register.
- R2: `mem_addr` is the PC when `ctl_addr_sel` is 0 and the ALU result register when it is 1.
- R3: The instruction register loads `mem_rdata` on a clock edge only when `ctl_ir_wr` is 1, and otherwise holds its value. `opcode` shows IR[31:26] and `funct` shows IR[5:0].
- R4: Operand latch A, operand latch B, the ALU result register and the memory data register reload on every clock edge. A and B take the register file values addressed by IR[25:21] and IR[20:16].
- R5: The first ALU operand is the PC when `ctl_srca_sel` is 0 and latch A when it is 1. The second operand is set by `ctl_srcb_sel`: 0 selects latch B, 1 selects the constant 4, 2 selects the sign-extended IR[15:0], and 3 selects that value shifted left by two.
- R6: `ctl_alu_op` chooses the ALU operation: 00 adds, 01 subtracts (first minus second), and 10 decodes `funct`. The funct codes are 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR and 0x2A signed set-less-than. Any other value adds.
- R7: The PC loads when `ctl_pc_wr` is 1, or when `ctl_pc_wr_cond` is 1 and the ALU result is zero, and holds otherwise. `ctl_pc_sel` 0 loads the live ALU result and 1 loads the ALU result register.
- R8: With `ctl_reg_wr` 1, a clock edge writes one register. The address is IR[20:16] when `ctl_dst_sel` is 0 and IR[15:11] when it is 1. The data is the ALU result register when `ctl_wb_sel` is 0 and the memory data register when it is 1.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: `mem_wdata` is always latch B, and `mem_wr` follows `ctl_mem_wr`.
- R11: The 16-bit immediate is sign-extended to 32 bits before it is used, both unscaled and scaled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_pc_wr | input | 1 | Unconditional PC load |
| ctl_pc_wr_cond | input | 1 | PC load when the ALU result is zero |
| ctl_pc_sel | input | 1 | PC source: 0 live ALU, 1 ALU result register |
| ctl_addr_sel | input | 1 | Memory address: 0 PC, 1 ALU result register |
| ctl_ir_wr | input | 1 | Instruction register load |
| ctl_mem_wr | input | 1 | Memory write request |
| ctl_reg_wr | input | 1 | Register file write |
| ctl_dst_sel | input | 1 | Write address: 0 IR[20:16], 1 IR[15:11] |
| ctl_wb_sel | input | 1 | Write data: 0 ALU result register, 1 memory data register |
| ctl_srca_sel | input | 1 | ALU operand one: 0 PC, 1 latch A |
| ctl_srcb_sel | input | 2 | ALU operand two: B, 4, immediate, immediate x4 |
| ctl_alu_op | input | 2 | 00 add, 01 subtract, 10 funct decode |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_wr | output | 1 | Memory write strobe |
| opcode | output | 6 | IR[31:26] for the sequencer |
| funct | output | 6 | IR[5:0] for the sequencer |

## Verification
The bench targets the branch path, covering taken, not-taken and backward branches. A datapath that loaded the live ALU result instead of the saved target would land on A-B rather than the target. One that ignored the conditional enable would jump on every branch. Signed set-less-than is checked with a negative operand, since an unsigned compare gives the opposite answer. A store with offset 0x8000 catches a missing sign extension. A write aimed at register 0 followed by a store of register 0 shows whether the zero register can be corrupted. The bench also blocks the instruction register and PC enables to confirm that nothing loads without its enable.

// File: rtl/mc_pkg.sv
// Shared types and field positions for the multicycle datapath.
// Assumes the fixed 32-bit instruction layout used by the sequencer.
package mc_pkg;
    localparam int OPC_LSB  = 26;
    localparam int RS_LSB   = 21;
    localparam int RT_LSB   = 16;
    localparam int RD_LSB   = 11;
    localparam int IMM_W    = 16;
    localparam int FIELD6_W = 6;

    localparam logic [5:0] FN_CODE_ADD = 6'h20;
    localparam logic [5:0] FN_CODE_SUB = 6'h22;
    localparam logic [5:0] FN_CODE_AND = 6'h24;
    localparam logic [5:0] FN_CODE_OR  = 6'h25;
    localparam logic [5:0] FN_CODE_SLT = 6'h2A;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10,
        AOP_RSVD  = 2'b11
    } alu_op_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_fn_e;

    typedef enum logic [1:0] {
        SRCB_REG   = 2'd0,
        SRCB_FOUR  = 2'd1,
        SRCB_IMM   = 2'd2,
        SRCB_IMMX4 = 2'd3
    } srcb_e;
endpackage

// File: rtl/mc_alu_ctrl.sv
// ALU operation decoder: maps the 2-bit operation class and the funct
// field onto an ALU function. Assumes unknown codes should add.
module mc_alu_ctrl
    import mc_pkg::*;
(
    input  logic [1:0] alu_op,
    input  logic [5:0] funct,
    output alu_fn_e    fn
);
    // Purpose: pick the ALU function from class and funct.
    always_comb begin
        fn = ALU_ADD;
        case (alu_op_e'(alu_op))
            AOP_SUB:   fn = ALU_SUB;
            AOP_FUNCT: begin
                case (funct)
                    FN_CODE_SUB: fn = ALU_SUB;
                    FN_CODE_AND: fn = ALU_AND;
                    FN_CODE_OR:  fn = ALU_OR;
                    FN_CODE_SLT: fn = ALU_SLT;
                    default:     fn = ALU_ADD;
                endcase
            end
            default:   fn = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/mc_alu.sv
// Single shared ALU: add, subtract, AND, OR and signed set-less-than,
// with a zero flag on the result. Purely combinational.
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);
    // Purpose: compute the selected operation.
    always_comb begin
        case (fn)
            ALU_SUB: y = op_a - op_b;
            ALU_AND: y = op_a & op_b;
            ALU_OR:  y = op_a | op_b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(op_a) < $signed(op_b))};
            default: y = op_a + op_b;
        endcase
    end

    // Purpose: flag an all-zero result for the branch compare.
    always_comb zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
// Register file with two combinational read ports and one write port.
// Entry 0 is not stored: it reads as zero and ignores writes.
// Assumes contents are undefined until software writes them.
module mc_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [W-1:0]  rd_data_a,
    output logic [W-1:0]  rd_data_b,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data
);
    logic [W-1:0] slots [DEPTH-1:1];

    // Purpose: write one register on the edge, skipping entry 0.
    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr != '0)) begin
            slots[wr_addr] <= wr_data;
        end
    end

    // Purpose: read both ports, forcing entry 0 to zero.
    always_comb begin
        rd_data_a = (rd_addr_a == '0) ? '0 : slots[rd_addr_a];
        rd_data_b = (rd_addr_b == '0) ? '0 : slots[rd_addr_b];
    end

    // R8
    rf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr != '0)) |=> (slots[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/mc_datapath.sv
// Multicycle datapath: PC, IR, MDR, operand latches, ALU result register,
// register file, one shared ALU and the selection muxes. All control is
// external. Assumes memory read data is valid in the same cycle as the
// address, and that only PC and IR are gated; other registers reload
// every cycle so the single ALU can be reused across steps.
module mc_datapath
    import mc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int REG_CNT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_pc_wr,
    input  logic              ctl_pc_wr_cond,
    input  logic              ctl_pc_sel,
    input  logic              ctl_addr_sel,
    input  logic              ctl_ir_wr,
    input  logic              ctl_mem_wr,
    input  logic              ctl_reg_wr,
    input  logic              ctl_dst_sel,
    input  logic              ctl_wb_sel,
    input  logic              ctl_srca_sel,
    input  logic [1:0]        ctl_srcb_sel,
    input  logic [1:0]        ctl_alu_op,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wr,
    output logic [5:0]        opcode,
    output logic [5:0]        funct
);
    localparam int REG_AW = $clog2(REG_CNT);
    localparam int EXT_W  = DATA_W - IMM_W;

    logic [DATA_W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
    logic [DATA_W-1:0] rf_a, rf_b, imm_sx, imm_x4;
    logic [DATA_W-1:0] alu_in_a, alu_in_b, alu_y, pc_next, wb_data;
    logic [REG_AW-1:0] wb_addr;
    logic              alu_zero, pc_en;
    alu_fn_e           alu_fn;

    // Purpose: sign-extend the immediate, unscaled and word-scaled.
    always_comb begin
        imm_sx = {{EXT_W{ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
        imm_x4 = imm_sx << 2;
    end

    // Purpose: select both ALU operands.
    always_comb begin
        alu_in_a = ctl_srca_sel ? a_q : pc_q;
        case (srcb_e'(ctl_srcb_sel))
            SRCB_FOUR:  alu_in_b = DATA_W'(4);
            SRCB_IMM:   alu_in_b = imm_sx;
            SRCB_IMMX4: alu_in_b = imm_x4;
            default:    alu_in_b = b_q;
        endcase
    end

    mc_alu_ctrl u_alu_ctrl (
        .alu_op (ctl_alu_op),
        .funct  (ir_q[FIELD6_W-1:0]),
        .fn     (alu_fn)
    );

    mc_alu #(.W(DATA_W)) u_alu (
        .op_a (alu_in_a),
        .op_b (alu_in_b),
        .fn   (alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Purpose: pick register write address and write data.
    always_comb begin
        wb_addr = ctl_dst_sel ? ir_q[RD_LSB +: REG_AW] : ir_q[RT_LSB +: REG_AW];
        wb_data = ctl_wb_sel  ? mdr_q : aluout_q;
    end

    mc_regfile #(.W(DATA_W), .DEPTH(REG_CNT), .AW(REG_AW)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_a (ir_q[RS_LSB +: REG_AW]),
        .rd_addr_b (ir_q[RT_LSB +: REG_AW]),
        .rd_data_a (rf_a),
        .rd_data_b (rf_b),
        .wr_en     (ctl_reg_wr),
        .wr_addr   (wb_addr),
        .wr_data   (wb_data)
    );

    // Purpose: PC enable and source selection.
    always_comb begin
        pc_en   = ctl_pc_wr | (ctl_pc_wr_cond & alu_zero);
        pc_next = ctl_pc_sel ? aluout_q : alu_y;
    end

    // Purpose: gated PC and IR with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            ir_q <= '0;
        end else begin
            if (pc_en)     pc_q <= pc_next;
            if (ctl_ir_wr) ir_q <= mem_rdata;
        end
    end

    // Purpose: ungated latches that reload every cycle.
    always_ff @(posedge clk) begin
        a_q      <= rf_a;
        b_q      <= rf_b;
        aluout_q <= alu_y;
        mdr_q    <= mem_rdata;
    end

    // Purpose: memory port and sequencer fields.
    always_comb begin
        mem_addr  = ctl_addr_sel ? aluout_q : pc_q;
        mem_wdata = b_q;
        mem_wr    = ctl_mem_wr;
        opcode    = ir_q[OPC_LSB +: FIELD6_W];
        funct     = ir_q[FIELD6_W-1:0];
    end

    // R7
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_pc_wr && !(ctl_pc_wr_cond && alu_zero)) |=> $stable(pc_q));

    // R7
    pc_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_pc_wr && ctl_pc_wr_cond && alu_zero && ctl_pc_sel) |=> (pc_q == $past(aluout_q)));

    // R3
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_ir_wr |=> $stable(ir_q));

    // R3
    ir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_ir_wr |=> (ir_q == $past(mem_rdata)));

    // R4
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((aluout_q == $past(alu_y)) && (mdr_q == $past(mem_rdata))));
endmodule

// File: tb/mc_datapath_tb.sv
// Bench: a small program walked from a vector table by a bench-side
// sequencer, then directed cases for enables, muxes and reset.
module mc_datapath_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 24;
    localparam logic [5:0] OP_R = 6'h00, OP_LW = 6'h23, OP_SW = 6'h2B, OP_BEQ = 6'h04;

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fc);
        return {6'h00, rs, rt, rd, 5'd0, fc};
    endfunction

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] ins;
        logic [31:0] ea;
        logic [31:0] wd;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{32'h00, enc_i(OP_LW, 0, 1, 16'h0100), 32'h0, 32'h0},
        '{32'h04, enc_i(OP_LW, 0, 2, 16'h0104), 32'h0, 32'h0},
        '{32'h08, enc_i(OP_LW, 0, 3, 16'h0108), 32'h0, 32'h0},
        '{32'h0C, enc_r(1, 2, 4, 6'h20),        32'h0, 32'h0},
        '{32'h10, enc_i(OP_SW, 0, 4, 16'h0110), 32'h110, 32'h4},
        '{32'h14, enc_r(1, 2, 5, 6'h22),        32'h0, 32'h0},
        '{32'h18, enc_i(OP_SW, 0, 5, 16'h0114), 32'h114, 32'hA},
        '{32'h1C, enc_r(1, 2, 6, 6'h24),        32'h0, 32'h0},
        '{32'h20, enc_i(OP_SW, 0, 6, 16'h0118), 32'h118, 32'h5},
        '{32'h24, enc_r(1, 3, 7, 6'h25),        32'h0, 32'h0},
        '{32'h28, enc_i(OP_SW, 0, 7, 16'h011C), 32'h11C, 32'h1234567F},
        '{32'h2C, enc_r(2, 1, 8, 6'h2A),        32'h0, 32'h0},
        '{32'h30, enc_i(OP_SW, 0, 8, 16'h0120), 32'h120, 32'h1},
        '{32'h34, enc_r(1, 2, 9, 6'h2A),        32'h0, 32'h0},
        '{32'h38, enc_i(OP_SW, 0, 9, 16'h0124), 32'h124, 32'h0},
        '{32'h3C, enc_r(1, 1, 0, 6'h20),        32'h0, 32'h0},
        '{32'h40, enc_i(OP_SW, 0, 0, 16'h0128), 32'h128, 32'h0},
        '{32'h44, enc_i(OP_SW, 3, 1, 16'h8000), 32'h1233D678, 32'h7},
        '{32'h48, enc_i(OP_BEQ, 1, 1, 16'h0002), 32'h0, 32'h0},
        '{32'h54, enc_i(OP_BEQ, 1, 2, 16'h0005), 32'h0, 32'h0},
        '{32'h58, enc_i(OP_BEQ, 9, 0, 16'h0001), 32'h0, 32'h0},
        '{32'h60, enc_i(OP_BEQ, 0, 0, 16'h0003), 32'h0, 32'h0},
        '{32'h70, enc_i(OP_BEQ, 0, 0, 16'hFFFD), 32'h0, 32'h0},
        '{32'h68, enc_i(OP_SW, 0, 2, 16'h012C), 32'h12C, 32'hFFFFFFFD}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_wr, pc_wr_cond, pc_sel, addr_sel, ir_wr, mem_wr_c, reg_wr;
    logic        dst_sel, wb_sel, srca_sel;
    logic [1:0]  srcb_sel, alu_op;
    logic [31:0] mem_rdata, mem_addr, mem_wdata;
    logic        mem_wr;
    logic [5:0]  opcode, funct;
    logic [31:0] mem [256];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_datapath dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_pc_wr(pc_wr), .ctl_pc_wr_cond(pc_wr_cond), .ctl_pc_sel(pc_sel),
        .ctl_addr_sel(addr_sel), .ctl_ir_wr(ir_wr), .ctl_mem_wr(mem_wr_c),
        .ctl_reg_wr(reg_wr), .ctl_dst_sel(dst_sel), .ctl_wb_sel(wb_sel),
        .ctl_srca_sel(srca_sel), .ctl_srcb_sel(srcb_sel), .ctl_alu_op(alu_op),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wr(mem_wr), .opcode(opcode), .funct(funct)
    );

    assign mem_rdata = mem[mem_addr[9:2]];

    // Memory model: preload, then write on the edge while strobed.
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        for (int k = 0; k < NVEC; k++) mem[VECS[k].pc[9:2]] = VECS[k].ins;
        mem[64] = 32'h00000007;
        mem[65] = 32'hFFFFFFFD;
        mem[66] = 32'h12345678;
        forever begin
            @(posedge clk);
            if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
        end
    end

    task automatic idle();
        {pc_wr, pc_wr_cond, pc_sel, addr_sel, ir_wr, mem_wr_c, reg_wr} = '0;
        {dst_sel, wb_sel, srca_sel} = '0;
        srcb_sel = 2'd0;
        alu_op   = 2'd0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        // fetch: IR <- mem[PC], PC <- PC + 4 through the live ALU
        idle(); ir_wr = 1'b1; srcb_sel = 2'd1; pc_wr = 1'b1;
        #2 chk("R7 pc before fetch", mem_addr, v.pc);
        tick();
        // decode: operands latched, branch target into ALU result register
        idle(); srcb_sel = 2'd3;
        #2 chk("R3 opcode", {26'd0, opcode}, {26'd0, v.ins[31:26]});
        chk("R3 funct", {26'd0, funct}, {26'd0, v.ins[5:0]});
        tick();
        case (v.ins[31:26])
            OP_R: begin
                idle(); srca_sel = 1'b1; alu_op = 2'b10; tick();
                idle(); reg_wr = 1'b1; dst_sel = 1'b1; tick();
            end
            OP_BEQ: begin
                idle(); srca_sel = 1'b1; alu_op = 2'b01; pc_wr_cond = 1'b1; pc_sel = 1'b1;
                tick();
            end
            OP_SW: begin
                idle(); srca_sel = 1'b1; srcb_sel = 2'd2; tick();
                idle(); addr_sel = 1'b1; mem_wr_c = 1'b1;
                #2 chk("R11 store address", mem_addr, v.ea);
                chk("R10 store data", mem_wdata, v.wd);
                chk("R10 write strobe", {31'd0, mem_wr}, 32'd1);
                tick();
            end
            default: begin
                idle(); srca_sel = 1'b1; srcb_sel = 2'd2; tick();
                idle(); addr_sel = 1'b1; tick();
                idle(); reg_wr = 1'b1; wb_sel = 1'b1; tick();
            end
        endcase
    endtask

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #2 chk("R1 pc after reset", mem_addr, 32'h0);
        chk("R1 ir after reset", {26'd0, opcode}, 32'h0);

        // Table walk: R2 R4 R5 R6 R7 R8 R9 R10 R11
        for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);
        idle();
        #2 chk("R7 final pc", mem_addr, 32'h6C);

        // R3/R7: IR and PC hold without enables; cond write with nonzero result
        idle(); srca_sel = 1'b1; alu_op = 2'b01; pc_wr_cond = 1'b1;
        tick();
        idle();
        #2 chk("R3 ir held", {26'd0, opcode}, {26'd0, OP_SW});
        chk("R7 pc held", mem_addr, 32'h6C);

        // R5/R11/R2: operand mux encodings observed through the address mux
        idle(); srca_sel = 1'b1; srcb_sel = 2'd2; tick();
        idle(); addr_sel = 1'b1; srca_sel = 1'b1; srcb_sel = 2'd3;
        #2 chk("R2 imm via result reg", mem_addr, 32'h12C);
        tick();
        idle(); addr_sel = 1'b1; srca_sel = 1'b1; srcb_sel = 2'd1;
        #2 chk("R5 scaled immediate", mem_addr, 32'h4B0);
        tick();
        idle(); addr_sel = 1'b1; alu_op = 2'b01;
        #2 chk("R5 constant four", mem_addr, 32'h4);
        tick();
        idle(); addr_sel = 1'b1;
        #2 chk("R5 pc minus latch B", mem_addr, 32'h6F);
        chk("R10 wdata is B", mem_wdata, 32'hFFFFFFFD);
        chk("R10 strobe low", {31'd0, mem_wr}, 32'd0);

        // R1: reset wins over a PC write
        idle(); pc_wr = 1'b1; srcb_sel = 2'd1; rst_n = 1'b0;
        tick();
        rst_n = 1'b1; idle();
        #2 chk("R1 reset over pc write", mem_addr, 32'h0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule